// File: doc/BRIEF.md
# Leakage-Ranked ALU Issue Binder

This block sits on the issue path in front of four ALUs and decides which ALU each ready operation goes to. Every ALU reports a small leakage code, where a larger code means a leakier unit. The block samples those codes all the time, but it rebuilds its priority order only at fixed epoch boundaries. The new order ranks the ALUs from least to most leaky. Between boundaries the order is frozen, so the issue path sees only a stable set of multiplexer selects.

Each cycle up to four operations arrive in numbered slots with valid bits. A power-gating controller supplies an availability mask. Valid operations are taken in slot order and placed on available ALUs in priority order, so the least leaky powered unit is always filled first. One 4-to-1 multiplexer per ALU input port performs the steering. Any operation that finds no free ALU is refused, and each slot reports whether it was accepted.

Top module: `lk_bind_top`

## Requirements
- R1: After reset the priority order is ALU0, ALU1, ALU2, ALU3 (ALU0 highest), and the epoch counter starts at zero. With all ALUs available, valid slot s then goes to ALU s.
- R2: The priority order changes only at the close of an epoch of EPOCH_LEN cycles. Counting rising edges after reset release from 1, the order rebuilt at edge k·EPOCH_LEN governs issue from that edge onward. This holds when the codes are stable for at least 3 cycles before that edge.
- R3: The rebuilt order lists the ALUs by ascending leakage code (code for ALU a at bits [3a+2:3a] of `alu_leak_code`). Equal codes are ordered by ascending ALU index.
- R4: The k-th valid operation in ascending slot order is issued to the k-th available ALU in priority order. An ALU receives work only if every available ALU ranked above it does too.
- R5: An ALU whose `alu_avail` bit is 0 is skipped in the fill order and never has `alu_issue` set.
- R6: `op_accept[s]` is 1 exactly when slot s is valid and fewer valid slots precede it than there are available ALUs. An invalid slot is never accepted.
- R7: For each issuing ALU a, `alu_sel` field a (bits [2a+1:2a]) holds the source slot, and `alu_op` field a holds that slot's data. Both fields are zero on an ALU that does not issue.
- R8: A change of leakage codes in mid-epoch has no effect on binding until the next epoch boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_leak_code | input | N_ALU*CODE_W | Per-ALU leakage code, larger is leakier |
| alu_avail | input | N_ALU | Per-ALU availability from the gating controller |
| op_valid | input | N_ALU | Per-slot operation valid |
| op_data | input | N_ALU*OP_W | Per-slot operation payload |
| alu_issue | output | N_ALU | Per-ALU operation issued this cycle |
| alu_sel | output | N_ALU*IDX_W | Per-ALU multiplexer select (source slot) |
| alu_op | output | N_ALU*OP_W | Per-ALU steered payload |
| op_accept | output | N_ALU | Per-slot accepted flag |

## Verification
Steering is combinational from the slot inputs and the registered order. The bench therefore checks `alu_issue`, `alu_sel`, `alu_op` and `op_accept` in the same cycle the inputs are driven, mid-cycle and away from the clock edge. The order is due one edge after the counter reaches EPOCH_LEN-1, which is edge k·EPOCH_LEN. The bench updates its own sorted model at exactly that edge and checks with all slots valid in the last cycle before each boundary and the first cycle after it. New codes are applied only in mid-epoch, well over three cycles before a boundary, and a check a few cycles later confirms they have not yet changed the binding.

// File: rtl/lk_bind_pkg.sv
package lk_bind_pkg;

  localparam int LK_CODE_MAX_W = 8;

  // Ordering rule for the rank: smaller code first, then smaller index.
  function automatic logic lk_goes_first(logic [LK_CODE_MAX_W-1:0] code_x, int idx_x,
                                         logic [LK_CODE_MAX_W-1:0] code_y, int idx_y);
    return (code_x < code_y) || ((code_x == code_y) && (idx_x < idx_y));
  endfunction

endpackage

// File: rtl/lk_epoch_timer.sv
module lk_epoch_timer #(
  parameter int EPOCH_LEN = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic epoch_tick
);
  localparam int CNT_W = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EPOCH_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign epoch_tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (epoch_tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  // R2: an epoch closes and the next one begins from zero
  p_epoch_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_tick |=> (cnt_q == '0));

  // R2: the counter never runs past the epoch length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/lk_rank_sorter.sv
module lk_rank_sorter
  import lk_bind_pkg::*;
#(
  parameter int N_ALU  = 4,
  parameter int CODE_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_ALU*CODE_W-1:0] leak_code,
  input  logic                    epoch_tick,
  output logic [N_ALU*IDX_W-1:0]  order_flat
);
  // stage 1: sampled codes
  logic [CODE_W-1:0] smp_q  [N_ALU];
  // stage 2: rank per ALU plus the codes that produced it
  logic [IDX_W-1:0]  pos_d  [N_ALU];
  logic [IDX_W-1:0]  pos_q  [N_ALU];
  logic [CODE_W-1:0] snap_q [N_ALU];
  // committed order (position -> ALU) and its codes, by position
  logic [IDX_W-1:0]  order_d [N_ALU];
  logic [IDX_W-1:0]  order_q [N_ALU];
  logic [CODE_W-1:0] cmt_code_q [N_ALU];

  always_comb begin
    for (int a = 0; a < N_ALU; a++) begin
      int ahead;
      ahead = 0;
      for (int j = 0; j < N_ALU; j++) begin
        if (j != a && lk_goes_first(LK_CODE_MAX_W'(smp_q[j]), j, LK_CODE_MAX_W'(smp_q[a]), a))
          ahead = ahead + 1;
      end
      pos_d[a] = IDX_W'(ahead);
    end
  end

  always_comb begin
    for (int p = 0; p < N_ALU; p++) order_d[p] = IDX_W'(p);
    for (int a = 0; a < N_ALU; a++) order_d[pos_q[a]] = IDX_W'(a);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < N_ALU; a++) begin
        smp_q[a]      <= '0;
        snap_q[a]     <= '0;
        pos_q[a]      <= IDX_W'(a);
        order_q[a]    <= IDX_W'(a);
        cmt_code_q[a] <= '0;
      end
    end else begin
      for (int a = 0; a < N_ALU; a++) begin
        smp_q[a]  <= leak_code[a*CODE_W +: CODE_W];
        snap_q[a] <= smp_q[a];
        pos_q[a]  <= pos_d[a];
      end
      if (epoch_tick) begin
        for (int p = 0; p < N_ALU; p++) begin
          order_q[p]    <= order_d[p];
          cmt_code_q[p] <= snap_q[order_d[p]];
        end
      end
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < N_ALU; gp++) begin : g_out
      assign order_flat[gp*IDX_W +: IDX_W] = order_q[gp];
    end
  endgenerate

  // Checks on the committed order
  logic [N_ALU-1:0] order_cover;
  logic             order_sorted;
  always_comb begin
    order_cover  = '0;
    order_sorted = 1'b1;
    for (int p = 0; p < N_ALU; p++) order_cover[order_q[p]] = 1'b1;
    for (int p = 0; p + 1 < N_ALU; p++) begin
      if (cmt_code_q[p] > cmt_code_q[p+1]) order_sorted = 1'b0;
      if (cmt_code_q[p] == cmt_code_q[p+1] && order_q[p] > order_q[p+1]) order_sorted = 1'b0;
    end
  end

  // R3: the committed order names every ALU exactly once
  p_order_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    &order_cover);

  // R3: ascending code, ties by ascending index
  p_order_sorted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    order_sorted);

  // R8: the order moves only at an epoch boundary
  p_order_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_tick |=> $stable(order_flat));

endmodule

// File: rtl/lk_issue_steer.sv
module lk_issue_steer #(
  parameter int N_ALU = 4,
  parameter int OP_W  = 16,
  parameter int IDX_W = 2
) (
  input  logic [N_ALU*IDX_W-1:0] order_flat,
  input  logic [N_ALU-1:0]       avail,
  input  logic [N_ALU-1:0]       op_valid,
  input  logic [N_ALU*OP_W-1:0]  op_data,
  output logic [N_ALU-1:0]       alu_issue,
  output logic [N_ALU*IDX_W-1:0] alu_sel,
  output logic [N_ALU*OP_W-1:0]  alu_op,
  output logic [N_ALU-1:0]       op_accept,
  output logic                   fill_gap
);
  localparam int CNT_W = IDX_W + 1;

  function automatic logic [CNT_W-1:0] ones_below(logic [N_ALU-1:0] v, int lim);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int q = 0; q < N_ALU; q++)
      if (q < lim) c = c + CNT_W'(v[q]);
    return c;
  endfunction

  logic [IDX_W-1:0] ord    [N_ALU];
  logic [IDX_W-1:0] pos_of [N_ALU];
  logic [N_ALU-1:0] avail_pos;
  logic [CNT_W-1:0] n_avail;
  logic [CNT_W-1:0] vrank  [N_ALU];

  always_comb begin
    for (int p = 0; p < N_ALU; p++) begin
      ord[p]       = order_flat[p*IDX_W +: IDX_W];
      avail_pos[p] = avail[ord[p]];
    end
    for (int a = 0; a < N_ALU; a++) begin
      pos_of[a] = '0;
      for (int p = 0; p < N_ALU; p++)
        if (ord[p] == IDX_W'(a)) pos_of[a] = IDX_W'(p);
    end
    n_avail = ones_below(avail, N_ALU);
    for (int s = 0; s < N_ALU; s++) begin
      vrank[s]     = ones_below(op_valid, s);
      op_accept[s] = op_valid[s] && (vrank[s] < n_avail);
    end
  end

  // One 4-to-1 select per ALU port
  always_comb begin
    for (int a = 0; a < N_ALU; a++) begin
      logic [CNT_W-1:0] arank;
      logic             hit;
      logic [IDX_W-1:0] src;
      arank = ones_below(avail_pos, int'(pos_of[a]));
      hit   = 1'b0;
      src   = '0;
      for (int s = 0; s < N_ALU; s++) begin
        if (op_valid[s] && vrank[s] == arank) begin
          hit = 1'b1;
          src = IDX_W'(s);
        end
      end
      alu_issue[a] = avail[a] && hit;
      alu_sel[a*IDX_W +: IDX_W] = alu_issue[a] ? src : '0;
      alu_op[a*OP_W +: OP_W]    = alu_issue[a] ? op_data[src*OP_W +: OP_W] : '0;
    end
  end

  // Observation: an issued ALU ranked below an idle available one
  always_comb begin
    logic idle_seen;
    idle_seen = 1'b0;
    fill_gap  = 1'b0;
    for (int p = 0; p < N_ALU; p++) begin
      if (avail_pos[p] && !alu_issue[ord[p]]) idle_seen = 1'b1;
      if (alu_issue[ord[p]] && idle_seen)     fill_gap  = 1'b1;
    end
  end

endmodule

// File: rtl/lk_bind_top.sv
module lk_bind_top #(
  parameter int N_ALU     = 4,
  parameter int CODE_W    = 3,
  parameter int OP_W      = 16,
  parameter int EPOCH_LEN = 10000,
  parameter int IDX_W     = (N_ALU > 1) ? $clog2(N_ALU) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_ALU*CODE_W-1:0] alu_leak_code,
  input  logic [N_ALU-1:0]        alu_avail,
  input  logic [N_ALU-1:0]        op_valid,
  input  logic [N_ALU*OP_W-1:0]   op_data,
  output logic [N_ALU-1:0]        alu_issue,
  output logic [N_ALU*IDX_W-1:0]  alu_sel,
  output logic [N_ALU*OP_W-1:0]   alu_op,
  output logic [N_ALU-1:0]        op_accept
);
  logic                   epoch_tick;
  logic [N_ALU*IDX_W-1:0] order_flat;
  logic                   fill_gap;

  lk_epoch_timer #(.EPOCH_LEN(EPOCH_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .epoch_tick(epoch_tick)
  );

  lk_rank_sorter #(.N_ALU(N_ALU), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_sorter (
    .clk(clk), .rst_n(rst_n), .leak_code(alu_leak_code),
    .epoch_tick(epoch_tick), .order_flat(order_flat)
  );

  lk_issue_steer #(.N_ALU(N_ALU), .OP_W(OP_W), .IDX_W(IDX_W)) u_steer (
    .order_flat(order_flat), .avail(alu_avail), .op_valid(op_valid), .op_data(op_data),
    .alu_issue(alu_issue), .alu_sel(alu_sel), .alu_op(alu_op),
    .op_accept(op_accept), .fill_gap(fill_gap)
  );

  // R4: work fills the available ALUs from the top of the order
  p_fill_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_gap);

  // R5: a gated ALU never issues
  p_gated_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_issue & ~alu_avail) == '0);

  // R6: one issue per accepted slot, and only valid slots accepted
  p_accept_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(alu_issue) == $countones(op_accept));
  p_accept_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_accept & ~op_valid) == '0);

endmodule

// File: tb/lk_bind_top_bench.sv
`timescale 1ns/1ps
module lk_bind_top_bench;
  localparam int N    = 4;
  localparam int CW   = 3;
  localparam int OW   = 16;
  localparam int L    = 40;
  localparam int IW   = 2;
  localparam int NCYC = 30 * L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*CW-1:0] alu_leak_code = '0;
  logic [N-1:0]    alu_avail = '0;
  logic [N-1:0]    op_valid = '0;
  logic [N*OW-1:0] op_data = '0;
  logic [N-1:0]    alu_issue;
  logic [N*IW-1:0] alu_sel;
  logic [N*OW-1:0] alu_op;
  logic [N-1:0]    op_accept;

  always #4 clk = ~clk;

  lk_bind_top #(.N_ALU(N), .CODE_W(CW), .OP_W(OW), .EPOCH_LEN(L)) u_lk_bind_top (
    .clk(clk), .rst_n(rst_n), .alu_leak_code(alu_leak_code), .alu_avail(alu_avail),
    .op_valid(op_valid), .op_data(op_data), .alu_issue(alu_issue), .alu_sel(alu_sel),
    .alu_op(alu_op), .op_accept(op_accept)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int order_exp [N];
  int codes [N];

  // Stable sort of ALU indices by (code, index)
  task automatic rebuild_order();
    int tmp;
    for (int i = 0; i < N; i++) order_exp[i] = i;
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0; j--)
        if (codes[order_exp[j]] < codes[order_exp[j-1]]) begin
          tmp = order_exp[j]; order_exp[j] = order_exp[j-1]; order_exp[j-1] = tmp;
        end
  endtask

  task automatic check_cycle(string tag, int n);
    logic [N-1:0]    e_issue, e_acc;
    logic [N*IW-1:0] e_sel;
    logic [N*OW-1:0] e_op;
    int k;
    string t_iss, t_acc, t_dat;
    e_issue = '0; e_acc = '0; e_sel = '0; e_op = '0;
    k = 0;
    for (int p = 0; p < N; p++) begin
      int a;
      a = order_exp[p];
      if (alu_avail[a]) begin
        while (k < N && !op_valid[k]) k++;
        if (k < N) begin
          e_issue[a] = 1'b1;
          e_sel[a*IW +: IW] = IW'(k);
          e_op[a*OW +: OW] = op_data[k*OW +: OW];
          e_acc[k] = 1'b1;
          k++;
        end
      end
    end
    t_iss = (tag != "") ? tag : ((alu_avail != '1) ? "R5" : "R4");
    t_acc = (tag != "") ? tag : "R6";
    t_dat = (tag != "") ? tag : "R7";
    checks += 3;
    if (alu_issue !== e_issue) begin
      failures++;
      $display("FAIL %s cycle %0d alu_issue act=%b exp=%b", t_iss, n, alu_issue, e_issue);
    end
    if (op_accept !== e_acc) begin
      failures++;
      $display("FAIL %s cycle %0d op_accept act=%b exp=%b", t_acc, n, op_accept, e_acc);
    end
    if (alu_sel !== e_sel || alu_op !== e_op) begin
      failures++;
      $display("FAIL %s cycle %0d sel/op act=%h/%h exp=%h/%h", t_dat, n, alu_sel, alu_op, e_sel, e_op);
    end
  endtask

  initial begin
    int unsigned seed_v;
    string tag;
    seed_v = $urandom(32'd1234);
    for (int a = 0; a < N; a++) codes[a] = 0;
    for (int p = 0; p < N; p++) order_exp[p] = p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // n = rising edges since reset release; here at the negedge after edge n
    for (int n = 0; n < NCYC; n++) begin
      int ph;
      ph = n % L;
      if (n > 0 && ph == 0) rebuild_order();
      if (ph == L/2) begin
        case (n / L)
          0: begin codes[0]=5; codes[1]=1; codes[2]=7; codes[3]=3; end
          1: begin codes[0]=2; codes[1]=2; codes[2]=2; codes[3]=2; end
          2: begin codes[0]=6; codes[1]=4; codes[2]=4; codes[3]=0; end
          3: begin codes[0]=7; codes[1]=7; codes[2]=0; codes[3]=7; end
          default: for (int a = 0; a < N; a++) codes[a] = int'($urandom_range(7, 0));
        endcase
        for (int a = 0; a < N; a++) alu_leak_code[a*CW +: CW] = CW'(codes[a]);
      end
      for (int s = 0; s < N; s++) op_data[s*OW +: OW] = OW'($urandom);
      tag = "";
      if (n == 0 || n == 1)     tag = "R1";
      else if (ph == 0)         tag = "R3";
      else if (ph == L-1)       tag = "R2";
      else if (ph == L/2 + 6)   tag = "R8";
      if (tag != "") begin
        op_valid = '1; alu_avail = '1;
      end else if (ph == 5) begin
        op_valid = '1; alu_avail = 4'b0101;        // two gated, two refused
      end else if (ph == 7) begin
        op_valid = 4'b1010; alu_avail = '0;        // nothing available
      end else begin
        op_valid  = N'($urandom);
        alu_avail = N'($urandom) | N'($urandom);
      end
      #2;
      check_cycle(tag, n);
      @(negedge clk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule